// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by consulting a one-level page table that lives in main memory. Software first loads a table start address and a table size (counted in entries) through a small configuration port. A requester then presents a virtual address together with an access kind: data read, data write or instruction fetch. The block takes the upper bits of the address as a page number and checks that number against the table size. It then fetches that page's entry with a single memory read and checks the entry's valid and permission bits.

When an access succeeds, the walker sets the entry's accessed bit. On a write it also sets the dirty bit. If either bit was previously clear, the walker stores the updated entry back to memory before it answers. The answer is a one-cycle completion pulse that carries either the translated address or a code naming the cause of the fault. The block handles one translation at a time and drives a plain request/response memory port with one request outstanding.

Top module: `pt_walker`

## Requirements
- R1: Writing through the configuration port with `cfg_sel`=0 loads the table start address, and with `cfg_sel`=1 loads the table size in entries. Both reset to 0, so after reset every request faults with the size-violation code.
- R2: `req_ready` is high only while the walker is idle. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. Each accepted request produces exactly one `done` pulse, one cycle wide.
- R3: The page number is `req_vaddr[31:12]`. An in-range request issues exactly one memory read, at byte address start + 4 × page number.
- R4: A page number greater than or equal to the table size completes with fault code 1 and makes no memory access.
- R5: An entry with bit 0 (valid) clear completes with fault code 2 and is not written back.
- R6: Entry bit 3 grants read, bit 4 grants write and bit 5 grants fetch. Access codes are 0 for read, 1 for write and 2 for fetch (3 behaves as read). An access whose permission bit is clear completes with fault code 3 (read), 4 (write) or 5 (fetch).
- R7: A successful access completes with fault code 0 and `done_paddr` = {entry[31:12], vaddr[11:0]}. A faulting access gives `done_paddr` = 0.
- R8: A successful access sets entry bit 1 (referenced), and a successful write also sets bit 2 (modified). If this changes the entry, it is written to the same address with all other bits unchanged, and the write completes before `done`.
- R9: If the referenced bit, and for a write also the modified bit, are already set, no memory write is issued.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table start address, 1 selects table size |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Response beat, one for each accepted request |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | Translation complete, one cycle |
| done_paddr | output | 32 | Physical address, 0 on fault |
| done_fault | output | 3 | 0 none, 1 size, 2 invalid, 3 read, 4 write, 5 fetch |

## Verification
The hardest case to reach is a writeback that meets memory backpressure. The write then has to wait through stalled cycles with its data held, and only afterwards may completion follow. The bench's memory model therefore has a mode in which ready alternates each cycle. A write to a page whose accessed and dirty bits start clear then forces both the read and the writeback to stall. The table size and start address are also reprogrammed during the run. This exercises the size boundary on both sides and entry addresses that do not begin at the first word.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int FAULT_W = 3;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   localparam logic [FAULT_W-1:0] FLT_NONE    = 3'd0;
   localparam logic [FAULT_W-1:0] FLT_SIZE    = 3'd1;
   localparam logic [FAULT_W-1:0] FLT_INVALID = 3'd2;
   localparam logic [FAULT_W-1:0] FLT_NOREAD  = 3'd3;
   localparam logic [FAULT_W-1:0] FLT_NOWRITE = 3'd4;
   localparam logic [FAULT_W-1:0] FLT_NOEXEC  = 3'd5;

   // status bit positions inside an entry
   localparam int E_VALID = 0;
   localparam int E_REF   = 1;
   localparam int E_MOD   = 2;
   localparam int E_RD    = 3;
   localparam int E_WR    = 4;
   localparam int E_EX    = 5;
   localparam int E_STATUS_BITS = 6;
endpackage

// File: rtl/ptw_cfg.sv
module ptw_cfg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] tbl_base,
   output logic [ADDR_W-1:0] tbl_size
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_base <= '0;
         tbl_size <= '0;
      end else if (cfg_we) begin
         if (cfg_sel) tbl_size <= cfg_wdata;
         else         tbl_base <= cfg_wdata;
      end
   end
endmodule

// File: rtl/ptw_check.sv
module ptw_check
   import ptw_pkg::*;
#(
   parameter int PTE_W = 32
) (
   input  logic [PTE_W-1:0]   pte,
   input  logic [1:0]         acc,
   output logic [FAULT_W-1:0] fault,
   output logic [PTE_W-1:0]   pte_upd,
   output logic               need_wb
);
   logic is_wr;

   always_comb begin
      is_wr = (acc == ACC_WRITE);
      fault = FLT_NONE;
      if (!pte[E_VALID]) begin
         fault = FLT_INVALID;
      end else begin
         unique case (acc)
            ACC_WRITE: if (!pte[E_WR]) fault = FLT_NOWRITE;
            ACC_FETCH: if (!pte[E_EX]) fault = FLT_NOEXEC;
            default:   if (!pte[E_RD]) fault = FLT_NOREAD;
         endcase
      end
      pte_upd        = pte;
      pte_upd[E_REF] = 1'b1;
      if (is_wr) pte_upd[E_MOD] = 1'b1;
      need_wb = (fault == FLT_NONE) && (pte_upd != pte);
   end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PTE_W     = 32,
   parameter int ADDR_W    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  tbl_base,
   input  logic [ADDR_W-1:0]  tbl_size,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_acc,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_write,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_rdata,
   output logic [PTE_W-1:0]   pte_q,
   output logic [1:0]         acc_q,
   input  logic [FAULT_W-1:0] chk_fault,
   input  logic               chk_need_wb,
   output logic               done,
   output logic [PTE_W-1:0]   done_paddr,
   output logic [FAULT_W-1:0] done_fault
);
   localparam int VPN_W   = VA_W - PAGE_BITS;
   localparam int WORD_SH = $clog2(PTE_W / 8);

   typedef enum logic [2:0] {
      S_IDLE, S_RD, S_RD_WAIT, S_EVAL, S_WR, S_WR_WAIT, S_DONE
   } state_e;

   state_e             state;
   logic [VA_W-1:0]    vaddr_q;
   logic [VPN_W-1:0]   vpn_in;
   logic [VPN_W-1:0]   vpn_q;

   assign vpn_in = req_vaddr[VA_W-1:PAGE_BITS];
   assign vpn_q  = vaddr_q[VA_W-1:PAGE_BITS];

   assign req_ready     = (state == S_IDLE);
   assign done          = (state == S_DONE);
   assign mem_req_valid = (state == S_RD) || (state == S_WR);
   assign mem_req_write = (state == S_WR);
   assign mem_req_addr  = tbl_base + (ADDR_W'(vpn_q) << WORD_SH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         vaddr_q    <= '0;
         acc_q      <= '0;
         pte_q      <= '0;
         done_paddr <= '0;
         done_fault <= FLT_NONE;
      end else begin
         unique case (state)
            S_IDLE: if (req_valid) begin
               vaddr_q <= req_vaddr;
               acc_q   <= req_acc;
               if (ADDR_W'(vpn_in) >= tbl_size) begin
                  done_fault <= FLT_SIZE;
                  done_paddr <= '0;
                  state      <= S_DONE;
               end else begin
                  state <= S_RD;
               end
            end
            S_RD:      if (mem_req_ready) state <= S_RD_WAIT;
            S_RD_WAIT: if (mem_rsp_valid) begin
               pte_q <= mem_rsp_rdata;
               state <= S_EVAL;
            end
            S_EVAL: begin
               done_fault <= chk_fault;
               if (chk_fault != FLT_NONE) begin
                  done_paddr <= '0;
                  state      <= S_DONE;
               end else begin
                  done_paddr <= {pte_q[PTE_W-1:PAGE_BITS], vaddr_q[PAGE_BITS-1:0]};
                  state      <= chk_need_wb ? S_WR : S_DONE;
               end
            end
            S_WR:      if (mem_req_ready) state <= S_WR_WAIT;
            S_WR_WAIT: if (mem_rsp_valid) state <= S_DONE;
            default:   state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PTE_W     = 32,
   parameter int ADDR_W    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [ADDR_W-1:0]  cfg_wdata,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_acc,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_write,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic [PTE_W-1:0]   mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_rdata,
   output logic               done,
   output logic [PTE_W-1:0]   done_paddr,
   output logic [FAULT_W-1:0] done_fault
);
   localparam int VPN_W   = VA_W - PAGE_BITS;
   localparam int WORD_SH = $clog2(PTE_W / 8);

   if (PAGE_BITS < E_STATUS_BITS || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("PAGE_BITS must leave room for status bits and a page number");
   end
   if ((PTE_W % 8) != 0 || PTE_W <= PAGE_BITS) begin : g_bad_pte
      $error("PTE_W must be whole bytes and wider than PAGE_BITS");
   end
   if (ADDR_W < VPN_W + WORD_SH) begin : g_bad_addr
      $error("ADDR_W too narrow to index the table");
   end

   logic [ADDR_W-1:0]  tbl_base;
   logic [ADDR_W-1:0]  tbl_size;
   logic [PTE_W-1:0]   pte_q;
   logic [1:0]         acc_q;
   logic [FAULT_W-1:0] chk_fault;
   logic               chk_need_wb;

   ptw_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .tbl_base(tbl_base), .tbl_size(tbl_size)
   );

   ptw_check #(.PTE_W(PTE_W)) u_check (
      .pte(pte_q), .acc(acc_q), .fault(chk_fault),
      .pte_upd(mem_req_wdata), .need_wb(chk_need_wb)
   );

   ptw_fsm #(
      .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PTE_W(PTE_W), .ADDR_W(ADDR_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_size(tbl_size),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .pte_q(pte_q), .acc_q(acc_q),
      .chk_fault(chk_fault), .chk_need_wb(chk_need_wb), .done(done),
      .done_paddr(done_paddr), .done_fault(done_fault)
   );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
   import ptw_pkg::*;
#(
   parameter int PTE_W  = 32,
   parameter int ADDR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               mem_req_valid,
   input logic               mem_req_ready,
   input logic               mem_req_write,
   input logic [ADDR_W-1:0]  mem_req_addr,
   input logic [PTE_W-1:0]   mem_req_wdata,
   input logic               done,
   input logic [PTE_W-1:0]   done_paddr,
   input logic [FAULT_W-1:0] done_fault
);
   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid
         && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata));

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);

   // R7
   fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && (done_fault != FLT_NONE) |-> (done_paddr == '0));

   // R8
   wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_wdata[E_REF] && mem_req_wdata[E_VALID]);
endmodule

bind pt_walker ptw_chk #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
   .mem_req_wdata(mem_req_wdata), .done(done), .done_paddr(done_paddr),
   .done_fault(done_fault)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_rdata;
   logic        done;
   logic [31:0] done_paddr;
   logic [2:0]  done_fault;

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [0:255];
   logic [31:0] base_addr = 32'h0000_2000;
   int          rd_count = 0;
   int          wr_count = 0;
   logic [31:0] last_rd_addr = '0;
   logic        stall = 1'b0;

   logic [31:0] got_paddr;
   logic [2:0]  got_fault;
   logic        busy_seen;
   logic        done_after;
   int          rd0, wr0;

   always #4 clk = ~clk;

   pt_walker u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_acc(req_acc), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .done(done), .done_paddr(done_paddr), .done_fault(done_fault)
   );

   // memory model: one response beat the cycle after each handshake
   always @(posedge clk) begin
      logic [31:0] off;
      if (!rst_n) begin
         mem_req_ready <= 1'b1;
         mem_rsp_valid <= 1'b0;
         mem_rsp_rdata <= '0;
      end else begin
         mem_rsp_valid <= 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            off = (mem_req_addr - 32'h0000_2000) >> 2;
            if (mem_req_write) begin
               mem[off[7:0]] = mem_req_wdata;
               wr_count = wr_count + 1;
            end else begin
               mem_rsp_rdata <= mem[off[7:0]];
               rd_count = rd_count + 1;
               last_rd_addr = mem_req_addr;
            end
            mem_rsp_valid <= 1'b1;
         end
         mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_req(input logic [31:0] va, input logic [1:0] acc);
      int n;
      rd0 = rd_count; wr0 = wr_count;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc;
      @(negedge clk);
      req_valid = 1'b0;
      busy_seen = req_ready;
      n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL R2: no completion, actual 0 expected 1");
         got_paddr = 'x; got_fault = 'x; done_after = 1'b0;
      end else begin
         got_paddr = done_paddr; got_fault = done_fault;
         @(negedge clk);
         done_after = done;
      end
   endtask

   task automatic t_reset();
      chk("R2 reset ready", {31'b0, req_ready}, 32'd1);
      chk("R2 reset done", {31'b0, done}, 32'd0);
      chk("R3 reset mem idle", {31'b0, mem_req_valid}, 32'd0);
      do_req(32'h0000_0123, 2'd0);
      chk("R1 size resets to zero", {29'b0, got_fault}, 32'd1);
      chk("R4 no access when size zero", rd_count - rd0, 0);
   endtask

   task automatic t_read_ok();
      mem[3] = 32'h1234_5000 | 32'h19;
      do_req(32'h0000_3ABC, 2'd0);
      chk("R7 read paddr", got_paddr, 32'h1234_5ABC);
      chk("R7 read fault", {29'b0, got_fault}, 32'd0);
      chk("R3 entry address", last_rd_addr, 32'h0000_200C);
      chk("R3 one read", rd_count - rd0, 1);
      chk("R8 ref writeback count", wr_count - wr0, 1);
      chk("R8 ref set", mem[3], 32'h1234_501B);
      chk("R2 busy after accept", {31'b0, busy_seen}, 32'd0);
      chk("R2 done one cycle", {31'b0, done_after}, 32'd0);
      do_req(32'h0000_3004, 2'd0);
      chk("R9 no write on repeat read", wr_count - wr0, 0);
      chk("R7 repeat paddr", got_paddr, 32'h1234_5004);
   endtask

   task automatic t_write();
      do_req(32'h0000_3010, 2'd1);
      chk("R8 write fault", {29'b0, got_fault}, 32'd0);
      chk("R8 dirty writeback", wr_count - wr0, 1);
      chk("R8 dirty set", mem[3], 32'h1234_501F);
      do_req(32'h0000_3020, 2'd1);
      chk("R9 no write when dirty", wr_count - wr0, 0);
   endtask

   task automatic t_perms();
      mem[4] = 32'h0000_7000 | 32'h09;
      do_req(32'h0000_4000, 2'd1);
      chk("R6 write denied", {29'b0, got_fault}, 32'd4);
      chk("R7 fault paddr", got_paddr, 32'd0);
      chk("R6 no wb on fault", wr_count - wr0, 0);
      chk("R6 entry unchanged", mem[4], 32'h0000_7009);
      do_req(32'h0000_4000, 2'd2);
      chk("R6 fetch denied", {29'b0, got_fault}, 32'd5);
      mem[5] = 32'hABCD_E000 | 32'h21;
      do_req(32'h0000_5FFF, 2'd2);
      chk("R6 fetch ok", got_paddr, 32'hABCD_EFFF);
      chk("R8 fetch sets ref", mem[5], 32'hABCD_E023);
      do_req(32'h0000_5000, 2'd0);
      chk("R6 read denied", {29'b0, got_fault}, 32'd3);
   endtask

   task automatic t_invalid();
      mem[6] = 32'h5555_5000 | 32'h18;
      do_req(32'h0000_6000, 2'd0);
      chk("R5 invalid fault", {29'b0, got_fault}, 32'd2);
      chk("R5 invalid paddr", got_paddr, 32'd0);
      chk("R5 no writeback", wr_count - wr0, 0);
      chk("R5 entry unchanged", mem[6], 32'h5555_5018);
   endtask

   task automatic t_size();
      do_req(32'h0001_0000, 2'd0);
      chk("R4 at size faults", {29'b0, got_fault}, 32'd1);
      chk("R4 no memory read", rd_count - rd0, 0);
      mem[15] = 32'h0F0F_0000 | 32'h0B;
      do_req(32'h0000_F123, 2'd0);
      chk("R4 last entry ok", got_paddr, 32'h0F0F_0123);
   endtask

   task automatic t_stall();
      mem[7] = 32'h0770_0000 | 32'h19;
      stall = 1'b1;
      do_req(32'h0000_7456, 2'd1);
      chk("R10 stalled paddr", got_paddr, 32'h0770_0456);
      chk("R10 stalled entry", mem[7], 32'h0770_001F);
      chk("R10 stalled writes", wr_count - wr0, 1);
      stall = 1'b0;
   endtask

   task automatic t_rebase();
      mem[16] = 32'h0BAD_0000 | 32'h0B;
      cfg_write(1'b0, 32'h0000_2040);
      do_req(32'h0000_0042, 2'd0);
      chk("R1 new start address", last_rd_addr, 32'h0000_2040);
      chk("R1 rebased paddr", got_paddr, 32'h0BAD_0042);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      cfg_write(1'b0, base_addr);
      cfg_write(1'b1, 32'd16);
      t_read_ok();
      t_write();
      t_perms();
      t_invalid();
      t_size();
      t_stall();
      t_rebase();
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule